// File: doc/BRIEF.md
# SPI Master, Clock Polarity 1 / Phase 0, with Word FIFOs

This block is an SPI bus master that only uses the clock mode where the serial clock idles high and data is captured on its falling edge. Software-side logic pushes outgoing words into an eight-entry transmit queue. The engine shifts each word out MSB first and, at the same time, collects the word arriving on the slave output line. Each received word goes into an eight-entry receive queue.

A frame starts when the block is enabled and the transmit queue holds data. The select line falls and the MOSI pad driver turns on. The first bit appears half a clock period later. If more words are queued when a word ends, the select line stays low and the next word follows with no gap. After the last word, select stays low for one more full clock period and then rises.

The word length can be set from 4 to 16 bits. A divider sets the clock half-period in system clocks. Both settings are captured when a frame starts, so they only change between frames.

Top module: `spi_mode2_master`

## Requirements
- R1: After reset and whenever no frame is running, `sck` is 1, `ssel_n` is 1, `mosi_oe` is 0 and `busy` is 0.
- R2: A frame starts only when `enable` is 1 and the transmit queue is not empty. At the start, `ssel_n` goes to 0 and `mosi_oe` goes to 1 in the same cycle. With `enable` at 0, queued words stay queued and `ssel_n` stays 1.
- R3: The first data bit is driven on `mosi` one half-period after `ssel_n` falls. The first falling edge of `sck` comes exactly two half-periods after `ssel_n` falls.
- R4: Words go out MSB first. Each word is `len` bits long, where `len` is `word_len`, raised to 4 if below 4 and lowered to 16 if above 16. Only the low `len` bits of a queued word are sent.
- R5: `miso` is sampled on each falling edge of `sck`, and `mosi` changes only on rising edges. Every high phase and every low phase of `sck` lasts `clk_div` system clocks, and a `clk_div` below 2 is treated as 2.
- R6: When a frame ends, `ssel_n` rises exactly two half-periods (one full `sck` period) after the last falling edge of `sck`.
- R7: If the transmit queue holds a word and `enable` is 1 when a word's last bit ends, the next word starts right away. Its MSB appears at that rising edge and `ssel_n` stays 0, so a whole burst is one select-low frame.
- R8: Each received word is right-justified to `len` bits, with the upper bits set to 0. It is written to the receive queue after its last bit is sampled.
- R9: If the receive queue is full when a word completes, the word is dropped and `rx_overrun` is set. `rx_overrun` stays set until reset.
- R10: Each queue holds 8 words of 16 bits and shows full and empty flags. A push to a full queue is ignored, and a pop from an empty queue is ignored.
- R11: Changes to `word_len` or `clk_div` while a frame is running have no effect until the next frame starts.
- R12: `busy` is 1 exactly while `ssel_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows new frames and new words to start |
| word_len | input | 5 | Bits per word, 4 to 16 (clamped) |
| clk_div | input | 8 | SCK half-period in system clocks, at least 2 |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to send, right-justified |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped |
| sck | output | 1 | Serial clock, idles high |
| ssel_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | MOSI pad driver enable; the pad is high-impedance when 0 |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A frame is running |

## Verification
The assertions check the following on every cycle:
- the idle line levels,
- that `busy` and `mosi_oe` follow the select line,
- that `mosi` never moves on a falling clock edge,
- that the overrun flag is sticky and is only set with the receive queue full,
- that no queue reports full and empty together.

Other behaviour can only be shown by the bench scenarios. These cover:
- the exact lead-in and tail lengths,
- the half-period length for several divider values,
- MSB-first word contents at the 4, 8, 12 and 16-bit lengths, and at a clamped length,
- a burst that stays inside one select-low frame,
- the word dropped on receive overflow,
- the deferral of setting changes made mid-frame.

// File: rtl/spi_m2_pkg.sv
// Shared constants, state type and helper functions for the SPI master.
// Assumes words are at most 16 bits and the divider input is 8 bits wide.
package spi_m2_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned LEN_W   = $clog2(WORD_W + 1);
    localparam int unsigned DIV_W   = 8;
    localparam int unsigned MIN_LEN = 4;
    localparam int unsigned MIN_DIV = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } eng_state_t;

    // Limit a requested word length to the supported range.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
        if (req < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
        if (req > LEN_W'(WORD_W))  return LEN_W'(WORD_W);
        return req;
    endfunction

    // Raise a requested divider to the smallest legal half-period.
    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] req);
        if (req < DIV_W'(MIN_DIV)) return DIV_W'(MIN_DIV);
        return req;
    endfunction

    // Move a right-justified word of the given length to the top of the shifter.
    function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] w,
                                                    input logic [LEN_W-1:0]  len);
        return w << (LEN_W'(WORD_W) - len);
    endfunction

endpackage

// File: rtl/spi_m2_fifo.sv
// Synchronous show-ahead FIFO. rdata is the head entry whenever empty is 0.
// A push while full or a pop while empty is ignored. Storage is not reset.
module spi_m2_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Step a pointer, wrapping at the configured depth.
    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write storage on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/spi_m2_engine.sv
// Serial engine for clock polarity 1, phase 0.
// Each half-period of SCK lasts div_q system clocks. A frame runs as:
// lead-in half, then high/low halves per bit, then a tail half.
// Word length and divider are captured at frame start.
// Assumes tx_word is valid whenever tx_empty is 0 (show-ahead queue).
module spi_m2_engine
    import spi_m2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              miso,
    output logic              sck,
    output logic              ssel_n,
    output logic              mosi,
    output logic              mosi_oe,
    output logic              busy,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word
);
    localparam int unsigned BIT_W = $clog2(WORD_W);

    eng_state_t        state;
    logic [DIV_W-1:0]  cnt, div_q;
    logic [LEN_W-1:0]  len_q;
    logic [BIT_W-1:0]  bits_left;
    logic [WORD_W-1:0] tx_sr, rx_sr, rx_next, chain_word;
    logic              tick, start, chain, sck_q, ssel_q, oe_q, mosi_q;

    assign tick       = (cnt == div_q - 1'b1);
    assign start      = (state == ST_IDLE) && enable && !tx_empty;
    assign chain      = (state == ST_LOW) && tick && (bits_left == '0) && enable && !tx_empty;
    assign tx_pop     = start || chain;
    assign rx_next    = {rx_sr[WORD_W-2:0], miso};
    assign chain_word = align_msb(tx_word, len_q);
    assign busy       = (state != ST_IDLE);
    assign sck        = sck_q;
    assign ssel_n     = ssel_q;
    assign mosi       = mosi_q;
    assign mosi_oe    = oe_q;

    // Half-period timer: restarts at frame start and at every phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE || tick) cnt <= '0;
        else                                    cnt <= cnt + 1'b1;
    end

    // Frame sequencer: line levels, shifters and receive hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sck_q     <= 1'b1;
            ssel_q    <= 1'b1;
            oe_q      <= 1'b0;
            mosi_q    <= 1'b0;
            len_q     <= LEN_W'(MIN_LEN);
            div_q     <= DIV_W'(MIN_DIV);
            bits_left <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            rx_push   <= 1'b0;
            rx_word   <= '0;
        end else begin
            rx_push <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    ssel_q    <= 1'b0;
                    oe_q      <= 1'b1;
                    len_q     <= clamp_len(word_len);
                    div_q     <= clamp_div(clk_div);
                    tx_sr     <= align_msb(tx_word, clamp_len(word_len));
                    bits_left <= BIT_W'(clamp_len(word_len) - 1'b1);
                    rx_sr     <= '0;
                    state     <= ST_LEAD;
                end
                ST_LEAD: if (tick) begin
                    mosi_q <= tx_sr[WORD_W-1];
                    state  <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    sck_q <= 1'b0;
                    rx_sr <= rx_next;
                    if (bits_left == '0) begin
                        rx_push <= 1'b1;
                        rx_word <= rx_next;
                    end
                    state <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    sck_q <= 1'b1;
                    if (bits_left != '0) begin
                        bits_left <= bits_left - 1'b1;
                        tx_sr     <= tx_sr << 1;
                        mosi_q    <= tx_sr[WORD_W-2];
                        state     <= ST_HIGH;
                    end else if (chain) begin
                        tx_sr     <= chain_word;
                        mosi_q    <= chain_word[WORD_W-1];
                        bits_left <= BIT_W'(len_q - 1'b1);
                        rx_sr     <= '0;
                        state     <= ST_HIGH;
                    end else begin
                        state <= ST_TAIL;
                    end
                end
                ST_TAIL: if (tick) begin
                    ssel_q <= 1'b1;
                    oe_q   <= 1'b0;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_mode2_master.sv
// Top level: transmit queue -> serial engine -> receive queue.
// Adds the sticky receive-overrun flag. The MOSI pad is expected to be
// a tri-state buffer driven by mosi and enabled by mosi_oe.
module spi_mode2_master
    import spi_m2_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tx_push,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              sck,
    output logic              ssel_n,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    output logic              busy
);
    logic [WORD_W-1:0] tx_head, rx_word;
    logic              tx_pop, rx_push;

    spi_m2_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spi_m2_engine u_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .word_len(word_len), .clk_div(clk_div),
        .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .miso(miso), .sck(sck), .ssel_n(ssel_n),
        .mosi(mosi), .mosi_oe(mosi_oe), .busy(busy),
        .rx_push(rx_push), .rx_word(rx_word)
    );

    spi_m2_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    // Sticky overrun: set when a completed word meets a full receive queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rx_overrun <= 1'b0;
        else if (rx_push && rx_full) rx_overrun <= 1'b1;
    end
endmodule

// File: rtl/spi_m2_checker.sv
// Cycle-level properties of the SPI master, bound onto the top module.
// Reads only top-level ports.
module spi_m2_checker (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic ssel_n,
    input logic mosi,
    input logic mosi_oe,
    input logic busy,
    input logic tx_full,
    input logic tx_empty,
    input logic rx_full,
    input logic rx_empty,
    input logic rx_overrun
);
    // R1: with select high, the clock rests high and the pad is released.
    p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ssel_n |-> (sck && !mosi_oe));

    // R2: the pad driver is on exactly while select is low.
    p_oe_follows_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe == !ssel_n);

    // R12: busy matches the select-low window.
    p_busy_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !ssel_n);

    // R5: data out never moves on a falling clock edge.
    p_mosi_hold_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> $stable(mosi));

    // R9: the overrun flag stays set once set.
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);

    // R9: the overrun flag is only set while the receive queue is full.
    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_full));

    // R10: no queue reports full and empty together.
    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

bind spi_mode2_master spi_m2_checker u_spi_m2_checker (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ssel_n(ssel_n), .mosi(mosi),
    .mosi_oe(mosi_oe), .busy(busy), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun)
);

// File: tb/test_spi_mode2_master.sv
// Scoreboard bench. Driver tasks queue expected MOSI words and slave replies.
// A negedge monitor acts as the slave: it captures MOSI on falling SCK,
// checks frame timing and feeds MISO.
module test_spi_mode2_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [4:0]  word_len = 5'd8;
    logic [7:0]  clk_div = 8'd2;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        rx_pop = 1'b0;
    logic        miso = 1'b0;
    logic        tx_full, tx_empty, rx_full, rx_empty, rx_overrun;
    logic        sck, ssel_n, mosi, mosi_oe, busy;
    logic [15:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Settings the slave model expects (changed only between frames).
    int exp_len = 8;
    int exp_div = 2;

    logic [15:0] exp_mosi[$];
    logic [15:0] reply_q[$];
    logic [15:0] exp_rx[$];

    // Monitor state.
    int   cyc = 0, t_sel = 0, t_edge = 0, t_last_fall = 0, bitcnt = 0;
    int   sel_falls = 0, sel_rises = 0;
    bit   first_fall = 1'b0, prev_sck = 1'b1, prev_sel = 1'b1;
    logic [15:0] mword = '0;

    always #5 clk = ~clk;

    spi_mode2_master i_spi_mode2_master (
        .clk(clk), .rst_n(rst_n), .enable(enable), .word_len(word_len),
        .clk_div(clk_div), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_overrun(rx_overrun), .sck(sck), .ssel_n(ssel_n), .mosi(mosi),
        .mosi_oe(mosi_oe), .miso(miso), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lenmask(input int len);
        return 16'((32'd1 << len) - 1);
    endfunction

    // Slave model and timing scoreboard.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_sel && !ssel_n) begin
                t_sel = cyc; first_fall = 1'b1; sel_falls++; bitcnt = 0; mword = '0;
            end
            if (prev_sck && !sck && !ssel_n) begin
                if (first_fall) chk(cyc - t_sel == 2 * exp_div, "R3 lead-in", cyc - t_sel, 2 * exp_div);
                else            chk(cyc - t_edge == exp_div, "R5 half-period", cyc - t_edge, exp_div);
                first_fall = 1'b0;
                mword = {mword[14:0], mosi};
                bitcnt++;
                if (bitcnt == exp_len) begin
                    if (exp_mosi.size() == 0) chk(1'b0, "R4 unexpected word", mword, 0);
                    else begin
                        logic [15:0] e;
                        e = exp_mosi.pop_front();
                        chk(mword == e, "R4 mosi word", mword, e);
                    end
                    chk(mosi_oe == 1'b1, "R2 pad enabled", mosi_oe, 1);
                    exp_rx.push_back((reply_q.size() != 0 ? reply_q.pop_front() : 16'h0) & lenmask(exp_len));
                    bitcnt = 0; mword = '0;
                end
                t_edge = cyc; t_last_fall = cyc;
            end
            if (!prev_sck && sck && !ssel_n) begin
                chk(cyc - t_edge == exp_div, "R5 half-period", cyc - t_edge, exp_div);
                t_edge = cyc;
            end
            if (!prev_sel && ssel_n) begin
                chk(cyc - t_last_fall == 2 * exp_div, "R6 tail", cyc - t_last_fall, 2 * exp_div);
                sel_rises++;
            end
            miso = (reply_q.size() != 0) ? reply_q[0][exp_len - 1 - bitcnt] : 1'b0;
        end
        prev_sck = sck;
        prev_sel = ssel_n;
    end

    task automatic push_tx(input logic [15:0] w, input logic [15:0] reply);
        while (tx_full) @(negedge clk);
        exp_mosi.push_back(w & lenmask(exp_len));
        reply_q.push_back(reply);
        tx_data = w; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy || !tx_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [15:0] e;
            e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 16'hDEAD;
            chk(!rx_empty && rx_data == e, req, rx_data, e);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
    endtask

    task automatic set_cfg(input int len_in, input int len_eff, input int div_in, input int div_eff);
        word_len = 5'(len_in); clk_div = 8'(div_in);
        exp_len = len_eff; exp_div = div_eff;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sck && ssel_n && !mosi_oe && !busy, "R1 idle levels", {sck, ssel_n, mosi_oe, busy}, 4'b1100);
        chk(tx_empty && rx_empty && !tx_full && !rx_overrun, "R10 reset flags", {tx_empty, rx_empty}, 2'b11);

        // Single 8-bit word, divider 2.
        enable = 1'b1;
        set_cfg(8, 8, 2, 2);
        push_tx(16'h00A5, 16'h003C);
        wait_idle();
        chk(sel_falls == 1 && sel_rises == 1, "R2 one frame", sel_falls, 1);
        drain(1, "R8 rx word len8");

        // Burst of three 12-bit words, divider 3, one frame (R7).
        set_cfg(12, 12, 3, 3);
        r0 = sel_rises;
        enable = 1'b0;
        push_tx(16'hF123, 16'h0ABC);
        push_tx(16'h0800, 16'h0555);
        push_tx(16'h0FFF, 16'h0001);
        enable = 1'b1;
        wait_idle();
        chk(sel_rises - r0 == 1, "R7 burst single frame", sel_rises - r0, 1);
        drain(3, "R8 rx words len12");

        // Boundary lengths: 4 and 16; clamped 2 -> 4 and 20 -> 16; divider 0 -> 2 (R4, R5).
        set_cfg(4, 4, 2, 2);   push_tx(16'h0009, 16'h0006); wait_idle(); drain(1, "R8 rx len4");
        set_cfg(16, 16, 5, 5); push_tx(16'h8001, 16'hC3A5); wait_idle(); drain(1, "R8 rx len16");
        set_cfg(2, 4, 0, 2);   push_tx(16'h00FA, 16'h000F); wait_idle(); drain(1, "R4 clamp low");
        set_cfg(20, 16, 1, 2); push_tx(16'h5A5A, 16'h1234); wait_idle(); drain(1, "R4 clamp high");

        // Enable gating (R2).
        set_cfg(8, 8, 2, 2);
        enable = 1'b0;
        push_tx(16'h0033, 16'h0044);
        repeat (40) @(negedge clk);
        chk(ssel_n && !busy && !tx_empty, "R2 held while disabled", ssel_n, 1);
        enable = 1'b1;
        wait_idle();
        drain(1, "R2 rx after enable");

        // Settings changed mid-frame are deferred (R11).
        push_tx(16'h0081, 16'h0018);
        while (!busy) @(negedge clk);
        repeat (4) @(negedge clk);
        word_len = 5'd12; clk_div = 8'd4;
        wait_idle();
        chk(exp_mosi.size() == 0, "R11 old length kept", exp_mosi.size(), 0);
        drain(1, "R11 rx old length");
        exp_len = 12; exp_div = 4;
        push_tx(16'h0C0C, 16'h0707);
        wait_idle();
        drain(1, "R11 new settings");

        // Queue full, ignored push, 8-word burst, then overrun (R10, R9).
        set_cfg(8, 8, 2, 2);
        enable = 1'b0;
        for (int i = 0; i < 8; i++) push_tx(16'(8'h10 + i), 16'(8'hE0 + i));
        chk(tx_full == 1'b1, "R10 tx full at 8", tx_full, 1);
        tx_data = 16'hFFFF; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
        r0 = sel_rises;
        enable = 1'b1;
        wait_idle();
        chk(sel_rises - r0 == 1, "R7 eight-word frame", sel_rises - r0, 1);
        chk(exp_mosi.size() == 0, "R10 ignored push", exp_mosi.size(), 0);
        chk(rx_full && !rx_overrun, "R9 exactly full no overrun", {rx_full, rx_overrun}, 2'b10);
        push_tx(16'h0077, 16'h0099);
        wait_idle();
        chk(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
        drain(8, "R9 kept words");
        void'(exp_rx.pop_front());
        chk(rx_empty && rx_overrun, "R9 dropped word and sticky flag", {rx_empty, rx_overrun}, 2'b11);
        chk(sck && ssel_n && !mosi_oe && !busy, "R12 idle at end", {sck, ssel_n, mosi_oe, busy}, 4'b1100);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule